// File: doc/BRIEF.md
# Stop-Mode Interrupt Wake-Up Controller

This block places the high-speed core clock domain into a gated low-power stop state and brings it back when an interrupt of sufficient priority arrives. Software programs two 8-bit registers. The wake control register holds an enable bit and a 3-bit priority threshold. The low-power control register holds a mode field that selects which stop mode is entered. Entry happens only when the processor reports that it has executed a stop instruction while wake-up is enabled.

While stopped, a combinational path arbitrates between the highest pending unmasked levels of two interrupt controllers and compares the winning level against the threshold. It is clocked only by the always-on clock. A qualifying level is registered as a wake request. The core clock enable returns one cycle later. The request is held until the clock generator confirms that the core clock is running, and the block then goes back to normal operation. The pending interrupt itself is left for the core to service.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, coreClkEn is 1, wakeReq is 0, lpMode is 0, and both registers read back 0, so wake-up is disabled.
- R2: A write with regSel=0 loads the wake control register and a write with regSel=1 loads the low-power control register. regRdData returns the register chosen by regSel.
- R3: When stopStrobe is high in normal operation and wake control bit 7 is 0, the strobe is ignored: coreClkEn stays 1 and lpMode stays 0.
- R4: When stopStrobe is high in normal operation and wake control bit 7 is 1, coreClkEn goes to 0 at the next clock edge and lpMode shows bits [1:0] of the low-power control register.
- R5: While stopped, a winning level of 7 always raises a wake request, even when the threshold (wake control bits [2:0]) is 7.
- R6: While stopped, a winning level strictly greater than the threshold raises a wake request. A level equal to or below the threshold, including level 0 (nothing pending), does not, and the clocks stay gated.
- R7: winLevel is the larger of ctl0Level and ctl1Level. winSrc is 0 when ctl0Level >= ctl1Level and is 1 only when ctl1Level is strictly higher. The wake comparison uses winLevel.
- R8: wakeReq rises at the first clock edge at which a qualifying level is seen in the stopped state. coreClkEn returns to 1 at the following edge.
- R9: wakeReq stays high until coreClkOn is sampled high while coreClkEn is 1. It then clears at that edge, lpMode returns to 0, and a new stop strobe is accepted.
- R10: Pending levels seen outside the stopped state never raise wakeReq, and a stopStrobe that arrives while stopped has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects wake control, 1 selects low-power control |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| stopStrobe | input | 1 | Processor reports that a stop instruction has executed |
| ctl0Level | input | 3 | Highest unmasked pending level, first controller |
| ctl1Level | input | 3 | Highest unmasked pending level, second controller |
| coreClkOn | input | 1 | Clock generator confirms that the core clock runs |
| coreClkEn | output | 1 | Core clock domain enable |
| wakeReq | output | 1 | Request to leave low-power mode |
| lpMode | output | 2 | Active stop mode, 0 in normal operation |
| winSrc | output | 1 | Controller that holds the winning level |
| winLevel | output | 3 | Winning pending level |

## Verification
The bench places pending levels exactly at the threshold, one above it, and at 7 with the threshold also at 7. A design that used >= would wake too early, and one that dropped the level-7 override would never wake at the top threshold. It presents equal levels on both controllers and a stronger level on the second controller only. A design with the tie-break reversed would report the wrong source. It also holds coreClkOn low after the clocks return, to catch a wake request that drops before the clock is confirmed. Finally, it sends stop strobes with wake-up disabled and while already stopped, and pending levels during normal running, to catch designs that gate clocks or raise wake requests when they should not.

// File: rtl/swk_pkg.sv
`timescale 1ns/1ps
package swk_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_ENTERING = 2'd1,
    ST_STOPPED  = 2'd2,
    ST_WAKING   = 2'd3
  } swkState_t;

  typedef struct packed {
    logic latchMode;
    logic clearMode;
    logic setWake;
    logic clearWake;
  } swkStrobe_t;
endpackage

// File: rtl/swk_level_arb.sv
`timescale 1ns/1ps
module swk_level_arb #(
  parameter int LVL_W   = 3,
  parameter int NUM_SRC = 2,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvlIn,
  output logic [SRC_W-1:0]              winIdx,
  output logic [LVL_W-1:0]              winLvl
);
  // Lower index keeps the win unless a later source is strictly higher.
  always_comb begin
    winIdx = '0;
    winLvl = lvlIn[0];
    for (int i = 1; i < NUM_SRC; i++) begin
      if (lvlIn[i] > winLvl) begin
        winLvl = lvlIn[i];
        winIdx = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/swk_datapath.sv
`timescale 1ns/1ps
module swk_datapath
  import swk_pkg::*;
#(
  parameter int LVL_W      = 3,
  parameter int REG_W      = 8,
  parameter int MODE_W     = 2,
  parameter int ENABLE_BIT = 7,
  localparam int MAX_LVL   = (1 << LVL_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [LVL_W-1:0]  ctl0Level,
  input  logic [LVL_W-1:0]  ctl1Level,
  input  swkStrobe_t        strobe,
  output logic              wakeEn,
  output logic              wakeHit,
  output logic              wakeReq,
  output logic [MODE_W-1:0] lpMode,
  output logic              winSrc,
  output logic [LVL_W-1:0]  winLevel
);
  logic [REG_W-1:0]  wakeCtlQ;
  logic [REG_W-1:0]  lpCtlQ;
  logic [LVL_W-1:0]  threshold;
  logic [1:0][LVL_W-1:0] levelVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCtlQ <= '0;
      lpCtlQ   <= '0;
    end else if (regWrEn) begin
      if (regSel) lpCtlQ   <= regWrData;
      else        wakeCtlQ <= regWrData;
    end
  end

  assign regRdData = regSel ? lpCtlQ : wakeCtlQ;
  assign wakeEn    = wakeCtlQ[ENABLE_BIT];
  assign threshold = wakeCtlQ[LVL_W-1:0];

  assign levelVec[0] = ctl0Level;
  assign levelVec[1] = ctl1Level;

  swk_level_arb #(.LVL_W(LVL_W), .NUM_SRC(2)) u_arb (
    .lvlIn  (levelVec),
    .winIdx (winSrc),
    .winLvl (winLevel)
  );

  // Combinational qualification path, usable while the core clock is gated.
  assign wakeHit = (winLevel == LVL_W'(MAX_LVL)) || (winLevel > threshold);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeReq <= 1'b0;
      lpMode  <= '0;
    end else begin
      if (strobe.setWake)        wakeReq <= 1'b1;
      else if (strobe.clearWake) wakeReq <= 1'b0;
      if (strobe.latchMode)      lpMode  <= lpCtlQ[MODE_W-1:0];
      else if (strobe.clearMode) lpMode  <= '0;
    end
  end
endmodule

// File: rtl/swk_control.sv
`timescale 1ns/1ps
module swk_control
  import swk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopStrobe,
  input  logic       wakeEn,
  input  logic       wakeHit,
  input  logic       coreClkOn,
  output swkStrobe_t strobe,
  output logic       coreClkEn
);
  swkState_t stateQ, stateD;
  logic      clkEnQ;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_RUN: begin
        if (stopStrobe && wakeEn) begin
          stateD           = ST_ENTERING;
          strobe.latchMode = 1'b1;
        end
      end
      ST_ENTERING: stateD = ST_STOPPED;
      ST_STOPPED: begin
        if (wakeHit) begin
          stateD         = ST_WAKING;
          strobe.setWake = 1'b1;
        end
      end
      ST_WAKING: begin
        if (clkEnQ && coreClkOn) begin
          stateD           = ST_RUN;
          strobe.clearWake = 1'b1;
          strobe.clearMode = 1'b1;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_RUN;
      clkEnQ <= 1'b1;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_RUN && stateD == ST_ENTERING) clkEnQ <= 1'b0;
      else if (stateQ == ST_WAKING && !clkEnQ)        clkEnQ <= 1'b1;
    end
  end

  assign coreClkEn = clkEnQ;
endmodule

// File: rtl/stop_wake_ctrl.sv
`timescale 1ns/1ps
module stop_wake_ctrl
  import swk_pkg::*;
#(
  parameter int LVL_W      = 3,
  parameter int REG_W      = 8,
  parameter int MODE_W     = 2,
  parameter int ENABLE_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              stopStrobe,
  input  logic [LVL_W-1:0]  ctl0Level,
  input  logic [LVL_W-1:0]  ctl1Level,
  input  logic              coreClkOn,
  output logic              coreClkEn,
  output logic              wakeReq,
  output logic [MODE_W-1:0] lpMode,
  output logic              winSrc,
  output logic [LVL_W-1:0]  winLevel
);
  swkStrobe_t strobe;
  logic       wakeEn;
  logic       wakeHit;

  swk_datapath #(
    .LVL_W(LVL_W), .REG_W(REG_W), .MODE_W(MODE_W), .ENABLE_BIT(ENABLE_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .ctl0Level (ctl0Level),
    .ctl1Level (ctl1Level),
    .strobe    (strobe),
    .wakeEn    (wakeEn),
    .wakeHit   (wakeHit),
    .wakeReq   (wakeReq),
    .lpMode    (lpMode),
    .winSrc    (winSrc),
    .winLevel  (winLevel)
  );

  swk_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .stopStrobe (stopStrobe),
    .wakeEn     (wakeEn),
    .wakeHit    (wakeHit),
    .coreClkOn  (coreClkOn),
    .strobe     (strobe),
    .coreClkEn  (coreClkEn)
  );
endmodule

// File: rtl/swk_checker.sv
`timescale 1ns/1ps
module swk_checker #(
  parameter int LVL_W  = 3,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopStrobe,
  input logic [LVL_W-1:0]  ctl0Level,
  input logic [LVL_W-1:0]  ctl1Level,
  input logic              coreClkOn,
  input logic              coreClkEn,
  input logic              wakeReq,
  input logic [MODE_W-1:0] lpMode,
  input logic              winSrc,
  input logic [LVL_W-1:0]  winLevel
);
  AST_GATE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreClkEn) |-> $past(stopStrobe)); // R4

  AST_WAKE_WHILE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReq) |-> $past(!coreClkEn)); // R8

  AST_CLK_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> $past(wakeReq)); // R8

  AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !(coreClkEn && coreClkOn)) |=> wakeReq); // R9

  AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && coreClkEn && coreClkOn) |=> !wakeReq); // R9

  AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (coreClkEn && !wakeReq) |-> (lpMode == '0)); // R9

  AST_NO_WAKE_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (coreClkEn && !wakeReq) |=> !wakeReq); // R10

  AST_WIN_IS_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (winLevel >= ctl0Level) && (winLevel >= ctl1Level)); // R7

  AST_TIE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (ctl0Level >= ctl1Level) |-> !winSrc); // R7

  AST_SECOND_STRICT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl1Level > ctl0Level) |-> winSrc); // R7
endmodule

bind stop_wake_ctrl swk_checker #(.LVL_W(LVL_W), .MODE_W(MODE_W)) u_swk_checker (
  .clk        (clk),
  .rstN       (rstN),
  .stopStrobe (stopStrobe),
  .ctl0Level  (ctl0Level),
  .ctl1Level  (ctl1Level),
  .coreClkOn  (coreClkOn),
  .coreClkEn  (coreClkEn),
  .wakeReq    (wakeReq),
  .lpMode     (lpMode),
  .winSrc     (winSrc),
  .winLevel   (winLevel)
);

// File: tb/stop_wake_ctrl_bench.sv
`timescale 1ns/1ps
module stop_wake_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       stopStrobe = 1'b0;
  logic [2:0] ctl0Level = '0;
  logic [2:0] ctl1Level = '0;
  logic       coreClkOn = 1'b0;
  logic       coreClkEn;
  logic       wakeReq;
  logic [1:0] lpMode;
  logic       winSrc;
  logic [2:0] winLevel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stop_wake_ctrl u_stop_wake_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .stopStrobe(stopStrobe),
    .ctl0Level(ctl0Level), .ctl1Level(ctl1Level), .coreClkOn(coreClkOn),
    .coreClkEn(coreClkEn), .wakeReq(wakeReq), .lpMode(lpMode),
    .winSrc(winSrc), .winLevel(winLevel)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Leaves the block in the stopped state at a negedge.
  task automatic enterStop(input int expMode);
    @(negedge clk);
    stopStrobe = 1'b1;
    @(negedge clk);
    stopStrobe = 1'b0;
    checkEq("R4 clock gated", int'(coreClkEn), 0);
    checkEq("R4 mode shown", int'(lpMode), expMode);
    @(negedge clk);
  endtask

  // Called at a negedge one cycle after wakeReq rose.
  task automatic finishWake();
    checkEq("R8 clock back", int'(coreClkEn), 1);
    checkEq("R9 request held", int'(wakeReq), 1);
    @(negedge clk);
    checkEq("R9 held without confirm", int'(wakeReq), 1);
    coreClkOn = 1'b1;
    @(negedge clk);
    checkEq("R9 request cleared", int'(wakeReq), 0);
    checkEq("R9 mode cleared", int'(lpMode), 0);
    coreClkOn = 1'b0;
    ctl0Level = '0; ctl1Level = '0;
  endtask

  task automatic tryLevels(input logic [2:0] l0, input logic [2:0] l1,
                           input bit expWake, input string req);
    ctl0Level = l0; ctl1Level = l1;
    @(negedge clk);
    checkEq(req, int'(wakeReq), int'(expWake));
    if (expWake) begin
      checkEq("R8 clock still gated", int'(coreClkEn), 0);
      @(negedge clk);
      finishWake();
    end else begin
      repeat (2) @(negedge clk);
      checkEq(req, int'(wakeReq), 0);
      checkEq(req, int'(coreClkEn), 0);
      ctl0Level = 3'd7; ctl1Level = 3'd0;
      @(negedge clk);
      checkEq("R5 exit wake", int'(wakeReq), 1);
      @(negedge clk);
      finishWake();
    end
  endtask

  task automatic tReset();
    @(negedge clk);
    checkEq("R1 clock enabled", int'(coreClkEn), 1);
    checkEq("R1 no wake", int'(wakeReq), 0);
    checkEq("R1 mode zero", int'(lpMode), 0);
    regSel = 1'b0; #1;
    checkEq("R1 wake reg zero", int'(regRdData), 0);
    regSel = 1'b1; #1;
    checkEq("R1 lp reg zero", int'(regRdData), 0);
  endtask

  task automatic tRegs();
    writeReg(1'b0, 8'h84);
    writeReg(1'b1, 8'hA6);
    regSel = 1'b0; #1;
    checkEq("R2 wake reg", int'(regRdData), 8'h84);
    regSel = 1'b1; #1;
    checkEq("R2 lp reg", int'(regRdData), 8'hA6);
  endtask

  task automatic tDisabled();
    writeReg(1'b0, 8'h03);
    @(negedge clk); stopStrobe = 1'b1;
    @(negedge clk); stopStrobe = 1'b0;
    checkEq("R3 clock kept", int'(coreClkEn), 1);
    checkEq("R3 mode kept", int'(lpMode), 0);
    @(negedge clk);
    checkEq("R3 clock kept later", int'(coreClkEn), 1);
  endtask

  task automatic tRunLevels();
    writeReg(1'b0, 8'h80);
    ctl0Level = 3'd7; ctl1Level = 3'd6;
    repeat (3) @(negedge clk);
    checkEq("R10 no wake in run", int'(wakeReq), 0);
    checkEq("R10 clock in run", int'(coreClkEn), 1);
    ctl0Level = '0; ctl1Level = '0;
  endtask

  task automatic tArbitration();
    ctl0Level = 3'd5; ctl1Level = 3'd5; #1;
    checkEq("R7 tie source", int'(winSrc), 0);
    checkEq("R7 tie level", int'(winLevel), 5);
    ctl0Level = 3'd2; ctl1Level = 3'd6; #1;
    checkEq("R7 second higher source", int'(winSrc), 1);
    checkEq("R7 second higher level", int'(winLevel), 6);
    ctl0Level = 3'd4; ctl1Level = 3'd3; #1;
    checkEq("R7 first higher source", int'(winSrc), 0);
    ctl0Level = '0; ctl1Level = '0;
  endtask

  task automatic tThresholds();
    writeReg(1'b0, 8'h84);   // enable, threshold 4
    writeReg(1'b1, 8'h02);
    enterStop(2);
    tryLevels(3'd4, 3'd4, 1'b0, "R6 equal no wake");
    enterStop(2);
    tryLevels(3'd0, 3'd0, 1'b0, "R6 level zero no wake");
    enterStop(2);
    tryLevels(3'd3, 3'd5, 1'b1, "R7 second wins and wakes");
    enterStop(2);
    tryLevels(3'd5, 3'd1, 1'b1, "R6 above threshold wakes");
  endtask

  task automatic tLevelSeven();
    writeReg(1'b0, 8'h87);   // enable, threshold 7
    writeReg(1'b1, 8'h01);
    enterStop(1);
    tryLevels(3'd6, 3'd6, 1'b0, "R6 below top threshold");
    enterStop(1);
    tryLevels(3'd0, 3'd7, 1'b1, "R5 level seven wakes");
  endtask

  task automatic tStrobeWhileStopped();
    writeReg(1'b0, 8'h85);
    writeReg(1'b1, 8'h03);
    enterStop(3);
    stopStrobe = 1'b1;
    @(negedge clk);
    stopStrobe = 1'b0;
    @(negedge clk);
    checkEq("R10 strobe stopped clock", int'(coreClkEn), 0);
    checkEq("R10 strobe stopped wake", int'(wakeReq), 0);
    checkEq("R10 strobe stopped mode", int'(lpMode), 3);
    tryLevels(3'd6, 3'd0, 1'b1, "R6 wake after strobe");
    enterStop(3);   // R9 re-entry accepted after a wake
    tryLevels(3'd7, 3'd7, 1'b1, "R9 second stop wakes");
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tDisabled();
    tRegs();
    tArbitration();
    tRunLevels();
    tThresholds();
    tLevelSeven();
    tStrobeWhileStopped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule